// File: doc/BRIEF.md
# Eight-bit timer with two compare channels and gated interrupts

The block is a free-running 8-bit counter that steps once for every cycle in which a timer-tick enable is high. Two 8-bit compare values, A and B, are checked against the counter on every tick. A match raises that channel's event flag. When the counter rolls over from 255 to 0, an overflow flag is raised. Each flag drives an interrupt request output only while its own mask bit and a global interrupt-enable input are both high. Software clears a flag by writing a one to its bit.

Software reaches the block through a small register port with an address, a write strobe, write data and registered read data. Through this port it can load the counter directly. A counter load masks compare detection on the next tick. This stops a freshly loaded value from firing a match that the counter did not reach by counting.

Top module: `tmr8_dualcmp`

## Requirements
- R1: After reset the counter, both compare values, the mask and all flags read as zero, and every interrupt output is low.
- R2: The counter steps up by one at the end of each cycle in which `tick` is high and no counter load is made. It holds in every other cycle, and it wraps from 255 to 0.
- R3: A write to address 0 loads the counter with `wdata` at the end of that cycle. The load takes precedence over a tick in the same cycle.
- R4: `rdata` presents the register selected by `addr` one cycle after the address is driven. The map is: 0 counter, 1 compare A, 2 compare B, 3 mask, 4 flags. Addresses 5 to 7 read as zero.
- R5: Compare A is written at address 1 and compare B at address 2. On a tick cycle that is not blocked, if the pre-tick counter value equals compare A, flag bit 1 is set at the end of that cycle. If it equals compare B, flag bit 2 is set.
- R6: Compare detection is suppressed on the first tick after a counter load, including when the loaded value equals a compare value. A tick that coincides with a load is not counted and cannot match.
- R7: A tick that finds the counter at 255 sets flag bit 0 (overflow) at the end of that cycle. Counter loads do not suppress this.
- R8: The mask at address 3 holds the compare-B enable at bit 2, the compare-A enable at bit 1 and the overflow enable at bit 0. Bits 7 to 3 always read zero, and writing them has no effect.
- R9: `irq_ovf`, `irq_cmpa` and `irq_cmpb` are each high exactly when flag bit 0, 1 or 2, the same mask bit and `gie` are all high.
- R10: Writing to address 4 clears every flag bit written as one and leaves the bits written as zero unchanged. A hardware set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Timer-tick enable |
| gie | input | 1 | Global interrupt enable |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Registered read data |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmpa | output | 1 | Compare-A interrupt request |
| irq_cmpb | output | 1 | Compare-B interrupt request |

## Verification
Every state change is due at the clock edge that ends the stimulus cycle. Counter loads, counter steps, flag sets and flag clears are visible just after that edge. Read data shows the addressed register's value from before that edge, and interrupt outputs follow the new flags at once combined with the current `gie`. The bench drives each vector on the falling edge. It advances its own cycle model across the rising edge and compares the outputs 1 ns after that edge, so every result is checked in the cycle it becomes due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_COUNT = 3'd0,
    RA_CMPA  = 3'd1,
    RA_CMPB  = 3'd2,
    RA_MASK  = 3'd3,
    RA_FLAG  = 3'd4
  } reg_addr_e;

  // flag / mask bit positions
  localparam int unsigned SRC_OVF  = 0;
  localparam int unsigned SRC_CMP0 = 1;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_o,
  output logic         cmp_ok_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         blk_q, blk_d;

  always_comb begin
    cnt_d = cnt_q;
    blk_d = blk_q;
    if (ld) begin
      cnt_d = ld_val;
      blk_d = 1'b1;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
      blk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign cmp_ok_o = tick & ~ld & ~blk_q;
  assign wrap_o   = tick & ~ld & (cnt_q == CNT_MAX);
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned W   = 8,
  parameter int unsigned NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          wr_en,
  input  logic [W-1:0]            wdata,
  input  logic [W-1:0]            cnt,
  input  logic                    cmp_ok,
  output logic [NCH-1:0][W-1:0]   cmp_val_o,
  output logic [NCH-1:0]          hit_o
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [W-1:0] cmp_q, cmp_d;

    always_comb begin
      cmp_d = cmp_q;
      if (wr_en[ch]) cmp_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q <= '0;
      else        cmp_q <= cmp_d;
    end

    assign cmp_val_o[ch] = cmp_q;
    assign hit_o[ch]     = cmp_ok & (cnt == cmp_q);
  end
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_wr,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] wbits,
  input  logic            gie,
  output logic [NSRC-1:0] flag_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] irq_o
);
  logic [NSRC-1:0] flag_q, flag_d;
  logic [NSRC-1:0] mask_q, mask_d;
  logic [NSRC-1:0] clr_bits;

  always_comb begin
    clr_bits = clr_wr ? wbits : '0;
    flag_d   = (flag_q & ~clr_bits) | set_i;
    mask_d   = mask_wr ? wbits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = flag_q & mask_q & {NSRC{gie}};
endmodule

// File: rtl/tmr8_dualcmp.sv
module tmr8_dualcmp
  import tmr_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              gie,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic              irq_ovf,
  output logic              irq_cmpa,
  output logic              irq_cmpb
);
  localparam int unsigned NCH  = 2;
  localparam int unsigned NSRC = NCH + 1;

  logic                  rst_ni;
  logic                  wr_cnt, wr_mask, wr_flag;
  logic [NCH-1:0]        wr_cmp;
  logic [CW-1:0]         cnt;
  logic                  cmp_ok, wrap;
  logic [NCH-1:0][CW-1:0] cmp_val;
  logic [NCH-1:0]        hit;
  logic [NSRC-1:0]       flag, mask, irq, set_src;
  logic [CW-1:0]         rd_d, rd_q;

  tmr_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_ni)
  );

  // write decode
  always_comb begin
    wr_cnt    = wr_en & (addr == RA_COUNT);
    wr_cmp[0] = wr_en & (addr == RA_CMPA);
    wr_cmp[1] = wr_en & (addr == RA_CMPB);
    wr_mask   = wr_en & (addr == RA_MASK);
    wr_flag   = wr_en & (addr == RA_FLAG);
  end

  tmr_counter #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ni),
    .tick     (tick),
    .ld       (wr_cnt),
    .ld_val   (wdata),
    .cnt_o    (cnt),
    .cmp_ok_o (cmp_ok),
    .wrap_o   (wrap)
  );

  tmr_match #(.W(CW), .NCH(NCH)) u_match (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en     (wr_cmp),
    .wdata     (wdata),
    .cnt       (cnt),
    .cmp_ok    (cmp_ok),
    .cmp_val_o (cmp_val),
    .hit_o     (hit)
  );

  always_comb begin
    set_src          = '0;
    set_src[SRC_OVF] = wrap;
    for (int i = 0; i < NCH; i++) set_src[SRC_CMP0 + i] = hit[i];
  end

  tmr_irq_ctl #(.NSRC(NSRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_ni),
    .set_i   (set_src),
    .clr_wr  (wr_flag),
    .mask_wr (wr_mask),
    .wbits   (wdata[NSRC-1:0]),
    .gie     (gie),
    .flag_o  (flag),
    .mask_o  (mask),
    .irq_o   (irq)
  );

  // registered read port
  always_comb begin
    rd_d = '0;
    case (addr)
      RA_COUNT: rd_d = cnt;
      RA_CMPA:  rd_d = cmp_val[0];
      RA_CMPB:  rd_d = cmp_val[1];
      RA_MASK:  rd_d[NSRC-1:0] = mask;
      RA_FLAG:  rd_d[NSRC-1:0] = flag;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rdata    = rd_q;
  assign irq_ovf  = irq[SRC_OVF];
  assign irq_cmpa = irq[SRC_CMP0];
  assign irq_cmpb = irq[SRC_CMP0 + 1];
endmodule

// File: rtl/tmr8_dualcmp_chk.sv
module tmr8_dualcmp_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          gie,
  input logic [2:0]    addr,
  input logic          wr_en,
  input logic [CW-1:0] wdata,
  input logic [CW-1:0] rdata,
  input logic          irq_ovf,
  input logic          irq_cmpa,
  input logic          irq_cmpb,
  input logic [CW-1:0] cnt,
  input logic [2:0]    flag,
  input logic [2:0]    mask,
  input logic          cmp_ok
);
  logic ld;
  assign ld = wr_en && (addr == 3'd0);

  assert_cnt_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(wdata)));

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld) |=> (cnt == $past(cnt) + 1'b1));

  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));

  assert_no_match_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !cmp_ok);

  assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld && (cnt == '1)) |=> flag[0]);

  assert_mask_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd3) |=> (rdata[CW-1:3] == '0));

  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 3'd5) |=> (rdata == '0));

  assert_irq_needs_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf || irq_cmpa || irq_cmpb) |-> gie);

  assert_irq_cmpb_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmpb |-> (flag[2] && mask[2]));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 3'd4) && wdata[0] && !(tick && (cnt == '1))) |=> !flag[0]);
endmodule

bind tmr8_dualcmp tmr8_dualcmp_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .tick     (tick),
  .gie      (gie),
  .addr     (addr),
  .wr_en    (wr_en),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq_ovf  (irq_ovf),
  .irq_cmpa (irq_cmpa),
  .irq_cmpb (irq_cmpb),
  .cnt      (cnt),
  .flag     (flag),
  .mask     (mask),
  .cmp_ok   (cmp_ok)
);

// File: tb/sim_tmr8_dualcmp.sv
`timescale 1ns/1ps
module sim_tmr8_dualcmp;
  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       gie;
  logic [2:0] addr;
  logic       wr_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq_ovf, irq_cmpa, irq_cmpb;

  int n_chk;
  int n_bad;

  // reference state, built from the requirements
  logic [7:0] m_cnt, m_a, m_b;
  logic [2:0] m_msk, m_flg;
  logic       m_blk;

  tmr8_dualcmp u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gie(gie), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_a;
      3'd2: return m_b;
      3'd3: return {5'b0, m_msk};
      3'd4: return {5'b0, m_flg};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1, 3'd2: return "R5";
      3'd3: return "R8";
      3'd4: return "R10";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic step(input bit t, input bit w, input logic [2:0] a,
                      input logic [7:0] d, input bit g, input string tag);
    logic [7:0] exp_rd;
    logic [2:0] set, clr, exp_irq;
    bit ld;
    @(negedge clk);
    tick = t; wr_en = w; addr = a; wdata = d; gie = g;
    exp_rd = ref_read(a);
    ld  = w && (a == 3'd0);
    set = 3'b000;
    if (t && !ld) begin
      set[0] = (m_cnt == 8'hFF);
      set[1] = !m_blk && (m_cnt == m_a);
      set[2] = !m_blk && (m_cnt == m_b);
    end
    clr   = (w && a == 3'd4) ? d[2:0] : 3'b000;
    m_flg = (m_flg & ~clr) | set;
    if (ld) begin
      m_cnt = d; m_blk = 1'b1;
    end else if (t) begin
      m_cnt = m_cnt + 8'd1; m_blk = 1'b0;
    end
    if (w && a == 3'd1) m_a = d;
    if (w && a == 3'd2) m_b = d;
    if (w && a == 3'd3) m_msk = d[2:0];
    exp_irq = m_flg & m_msk & {3{g}};
    @(posedge clk);
    #1;
    chk((tag == "") ? addr_tag(a) : tag, "rdata", rdata, exp_rd);
    chk("R9", "irq", {5'b0, irq_cmpb, irq_cmpa, irq_ovf}, {5'b0, exp_irq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    m_cnt = 0; m_a = 0; m_b = 0; m_msk = 0; m_flg = 0; m_blk = 0;
    rst_n = 1'b0; tick = 0; gie = 0; addr = 0; wr_en = 0; wdata = 0;
    void'($urandom(32'd4242));

    // R1: state while in reset and right after release
    repeat (3) @(negedge clk);
    chk("R1", "rdata in reset", rdata, 8'h00);
    chk("R1", "irq in reset", {5'b0, irq_cmpb, irq_cmpa, irq_ovf}, 8'h00);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 3'd0, 8'h00, 0, "R1");
    for (int i = 0; i < 6; i++) step(0, 0, 3'(i), 8'h00, 1, "R1");

    // R2 / R7: count through the wrap, then inspect the overflow flag
    step(0, 1, 3'd0, 8'd250, 1, "R3");
    for (int i = 0; i < 10; i++) step(1, 0, 3'd0, 8'h00, 1, "R2");
    step(0, 0, 3'd0, 8'h00, 1, "R2");
    step(0, 0, 3'd4, 8'h00, 1, "R7");
    step(0, 0, 3'd4, 8'h00, 1, "R7");

    // R8: reserved mask bits ignored
    step(0, 1, 3'd3, 8'hFF, 1, "R8");
    step(0, 0, 3'd3, 8'h00, 1, "R8");
    step(0, 0, 3'd3, 8'h00, 0, "R9");
    step(0, 1, 3'd4, 8'h07, 1, "R10");

    // R6: loaded value equal to compare A does not match on next tick
    step(0, 1, 3'd1, 8'd5, 1, "R5");
    step(0, 1, 3'd0, 8'd5, 1, "R3");
    step(1, 0, 3'd4, 8'h00, 1, "R6");
    step(0, 0, 3'd4, 8'h00, 1, "R6");
    // R3: load with a tick in the same cycle, load wins
    step(1, 1, 3'd0, 8'd5, 1, "R3");
    step(0, 0, 3'd0, 8'h00, 1, "R3");
    step(1, 0, 3'd4, 8'h00, 1, "R6");
    // R5: a counted arrival at compare A does match
    step(0, 1, 3'd0, 8'd4, 1, "R3");
    step(1, 0, 3'd4, 8'h00, 1, "R5");
    step(1, 0, 3'd4, 8'h00, 1, "R5");
    step(0, 0, 3'd4, 8'h00, 1, "R5");

    // R10: compare-B set wins over a simultaneous clear
    step(0, 1, 3'd2, 8'h20, 1, "R5");
    step(0, 1, 3'd0, 8'h1F, 1, "R3");
    step(1, 0, 3'd0, 8'h00, 1, "R6");
    step(1, 1, 3'd4, 8'h07, 1, "R10");
    step(0, 0, 3'd4, 8'h00, 1, "R10");
    step(0, 1, 3'd4, 8'h02, 1, "R10");
    step(0, 0, 3'd4, 8'h00, 1, "R10");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      bit t, w, g;
      logic [2:0] a;
      logic [7:0] d;
      t = ($urandom % 2) == 0;
      w = ($urandom % 4) == 0;
      g = ($urandom % 4) != 0;
      a = 3'($urandom % 8);
      case ($urandom % 4)
        0: d = m_a;
        1: d = m_b;
        2: d = 8'hFE;
        default: d = 8'($urandom);
      endcase
      if (w && a == 3'd4 && ($urandom % 2) == 0) d = 8'h00;
      step(t, w, a, d, g, "");
    end

    summary();
    $finish;
  end
endmodule